// File: doc/BRIEF.md
# Byte-Lane Static RAM Sequencer

This block sits between a synchronous host and an external asynchronous static RAM of 262,144 sixteen-bit words. Each word is split into two byte lanes, and each lane has its own active-low enable pin. The host issues one request at a time over a valid/ready handshake. A request carries a read/write flag, an 18-bit word address, 16 bits of write data and a 2-bit lane mask. The sequencer turns that request into a chip-enable, write-enable and output-enable waveform timed in whole clock cycles. It drives the lane enables from the mask. For reads it returns the captured word on a one-cycle response strobe.

On the host side, back-pressure works as follows. `req_ready` is high only while the sequencer is idle. A request is taken on any clock edge where `req_valid` and `req_ready` are both high, and `req_ready` stays low from that edge until the access ends. The response strobe cannot be held off: the host must take `rsp_rdata` in the cycle `rsp_valid` is high. The shared data pins are modelled as an outgoing bus, an incoming bus and a drive-enable. The sequencer drives the pins only inside the write-enable low pulse. It releases them at least a cycle before any output enable.

Top module: `sram_byte_ctl`

## Requirements
- R1: After reset, `req_ready` is 1, `mem_ce_n`, `mem_we_n`, `mem_oe_n`, `mem_lb_n`, `mem_ub_n` are 1, and `mem_dq_oe` and `rsp_valid` are 0.
- R2: A request is accepted on an edge with `req_valid` and `req_ready` high. For a non-empty mask, `req_ready` then stays low for WRITE_CYCLES+2 cycles on a write and READ_CYCLES cycles on a read, and `mem_ce_n` is never low while `req_ready` is high.
- R3: On a write, chip enable, lane enables and address settle one cycle before `mem_we_n` falls. `mem_we_n` stays low for exactly WRITE_CYCLES cycles. Chip enable, lane enables and address are held for one cycle after it rises.
- R4: Mask bit 0 set drives `mem_lb_n` low (data bits 7:0), and mask bit 1 set drives `mem_ub_n` low (bits 15:8), for the whole access. A clear mask bit keeps its lane enable high, so that memory byte is left unchanged by a write.
- R5: `mem_dq_oe` is 1 only while `mem_we_n` is low, and `mem_dq_out` then equals the write data of the request.
- R6: On a read with a non-empty mask, `mem_ce_n` and `mem_oe_n` are low and `mem_we_n` high for exactly READ_CYCLES cycles. `mem_dq_oe` is 0 in every cycle where `mem_oe_n` is low and in the cycle before it falls.
- R7: Read data is sampled from `mem_dq_in` at the end of the last output-enable cycle. `rsp_valid` is high in the next cycle, READ_CYCLES edges after the accepting edge. Bits of a lane whose mask bit is clear read as zero.
- R8: A request with mask 00 never lowers `mem_ce_n`, and `req_ready` stays high. For a read, `rsp_valid` is high in the cycle right after the accepting edge with `rsp_rdata` = 0. For a write, the memory is unchanged.
- R9: `rsp_valid` is raised once per accepted read and never for a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle, request can be taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 18 | Word address |
| req_wdata | input | 16 | Write data |
| req_mask | input | 2 | Lane mask, bit 0 = bits 7:0, bit 1 = bits 15:8 |
| rsp_valid | output | 1 | One-cycle read-data strobe |
| rsp_rdata | output | 16 | Read data, disabled lanes zero |
| mem_addr | output | 18 | Memory address pins |
| mem_ce_n | output | 1 | Chip enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_lb_n | output | 1 | Low-lane enable, active low |
| mem_ub_n | output | 1 | High-lane enable, active low |
| mem_dq_out | output | 16 | Data toward the memory |
| mem_dq_in | input | 16 | Data from the memory |
| mem_dq_oe | output | 1 | Sequencer drives the data pins |

## Verification
Counting from the accepting edge, read data is due READ_CYCLES edges later for a non-empty mask and 0 edges later for mask 00. `req_ready` comes back after WRITE_CYCLES+2 cycles on a write or READ_CYCLES cycles on a read. The driver stamps each accepted read with its due edge count in the scoreboard queue. The monitor samples on falling edges and compares both the data and the edge count when it pops. The pin monitor measures the write-enable pulse and the setup, hold and bus-release cycles against the same edge counter. A behavioural memory model answers the read pins.

// File: rtl/sram_byte_ctl_pkg.sv
package sram_byte_ctl_pkg;
  localparam int LANE_W = 8;
  localparam int LANES  = 2;
  localparam int WORD_W = LANE_W * LANES;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WSETUP,
    ST_WPULSE,
    ST_WHOLD,
    ST_RACC
  } seq_state_e;
endpackage

// File: rtl/sram_byte_ctl_timer.sv
module sram_byte_ctl_timer #(
  parameter int CNT_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)            cnt_q <= '0;
    else if (load)         cnt_q <= load_val;
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign expired = (cnt_q == '0);
endmodule

// File: rtl/sram_byte_ctl_seq.sv
module sram_byte_ctl_seq
  import sram_byte_ctl_pkg::*;
#(
  parameter int READ_CYCLES  = 2,
  parameter int WRITE_CYCLES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_valid,
  input  logic req_write,
  input  logic mask_any,
  output logic req_ready,
  output logic load,
  output logic capture,
  output logic zero_rsp,
  output logic active_next,
  output logic mem_ce_n,
  output logic mem_we_n,
  output logic mem_oe_n,
  output logic mem_dq_oe,
  output logic rsp_valid
);
  localparam int MAXC  = (READ_CYCLES > WRITE_CYCLES) ? READ_CYCLES : WRITE_CYCLES;
  localparam int CNT_W = (MAXC < 2) ? 1 : $clog2(MAXC);

  seq_state_e       state_q, state_d;
  logic             tmr_load, tmr_zero;
  logic [CNT_W-1:0] tmr_val;

  sram_byte_ctl_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .expired  (tmr_zero)
  );

  always_comb begin
    state_d  = state_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    load     = 1'b0;
    capture  = 1'b0;
    zero_rsp = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (req_valid) begin
          load = 1'b1;
          if (!mask_any) begin
            zero_rsp = !req_write;
          end else if (req_write) begin
            state_d = ST_WSETUP;
          end else begin
            state_d  = ST_RACC;
            tmr_load = 1'b1;
            tmr_val  = CNT_W'(READ_CYCLES - 1);
          end
        end
      end
      ST_WSETUP: begin
        state_d  = ST_WPULSE;
        tmr_load = 1'b1;
        tmr_val  = CNT_W'(WRITE_CYCLES - 1);
      end
      ST_WPULSE: if (tmr_zero) state_d = ST_WHOLD;
      ST_WHOLD:  state_d = ST_IDLE;
      ST_RACC: begin
        if (tmr_zero) begin
          state_d = ST_IDLE;
          capture = 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  assign req_ready   = (state_q == ST_IDLE);
  assign active_next = (state_d != ST_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      mem_ce_n  <= 1'b1;
      mem_we_n  <= 1'b1;
      mem_oe_n  <= 1'b1;
      mem_dq_oe <= 1'b0;
      rsp_valid <= 1'b0;
    end else begin
      state_q   <= state_d;
      mem_ce_n  <= (state_d == ST_IDLE);
      mem_we_n  <= (state_d != ST_WPULSE);
      mem_oe_n  <= (state_d != ST_RACC);
      mem_dq_oe <= (state_d == ST_WPULSE);
      rsp_valid <= capture | zero_rsp;
    end
  end
endmodule

// File: rtl/sram_byte_ctl_lane.sv
module sram_byte_ctl_lane
  import sram_byte_ctl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              mask_bit,
  input  logic              active_next,
  input  logic              capture,
  input  logic              zero_rsp,
  input  logic [LANE_W-1:0] wr_byte,
  input  logic [LANE_W-1:0] rd_byte,
  output logic              be_n,
  output logic [LANE_W-1:0] dq_byte,
  output logic [LANE_W-1:0] rsp_byte
);
  logic en_q, en_next;

  assign en_next = load ? mask_bit : en_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q     <= 1'b0;
      be_n     <= 1'b1;
      dq_byte  <= '0;
      rsp_byte <= '0;
    end else begin
      en_q <= en_next;
      be_n <= !(active_next && en_next);
      if (load) dq_byte <= wr_byte;
      if (zero_rsp)     rsp_byte <= '0;
      else if (capture) rsp_byte <= en_q ? rd_byte : '0;
    end
  end
endmodule

// File: rtl/sram_byte_ctl.sv
module sram_byte_ctl
  import sram_byte_ctl_pkg::*;
#(
  parameter int ADDR_W       = 18,
  parameter int READ_CYCLES  = 2,
  parameter int WRITE_CYCLES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [WORD_W-1:0] req_wdata,
  input  logic [LANES-1:0]  req_mask,
  output logic              rsp_valid,
  output logic [WORD_W-1:0] rsp_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_ce_n,
  output logic              mem_we_n,
  output logic              mem_oe_n,
  output logic              mem_lb_n,
  output logic              mem_ub_n,
  output logic [WORD_W-1:0] mem_dq_out,
  input  logic [WORD_W-1:0] mem_dq_in,
  output logic              mem_dq_oe
);
  logic             load, capture, zero_rsp, active_next;
  logic [LANES-1:0] be_n;

  sram_byte_ctl_seq #(
    .READ_CYCLES  (READ_CYCLES),
    .WRITE_CYCLES (WRITE_CYCLES)
  ) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_write   (req_write),
    .mask_any    (|req_mask),
    .req_ready   (req_ready),
    .load        (load),
    .capture     (capture),
    .zero_rsp    (zero_rsp),
    .active_next (active_next),
    .mem_ce_n    (mem_ce_n),
    .mem_we_n    (mem_we_n),
    .mem_oe_n    (mem_oe_n),
    .mem_dq_oe   (mem_dq_oe),
    .rsp_valid   (rsp_valid)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    sram_byte_ctl_lane u_lane (
      .clk         (clk),
      .rst_n       (rst_n),
      .load        (load),
      .mask_bit    (req_mask[g]),
      .active_next (active_next),
      .capture     (capture),
      .zero_rsp    (zero_rsp),
      .wr_byte     (req_wdata[g*LANE_W +: LANE_W]),
      .rd_byte     (mem_dq_in[g*LANE_W +: LANE_W]),
      .be_n        (be_n[g]),
      .dq_byte     (mem_dq_out[g*LANE_W +: LANE_W]),
      .rsp_byte    (rsp_rdata[g*LANE_W +: LANE_W])
    );
  end

  assign mem_lb_n = be_n[0];
  assign mem_ub_n = be_n[1];

  always_ff @(posedge clk) begin
    if (!rst_n)    mem_addr <= '0;
    else if (load) mem_addr <= req_addr;
  end
endmodule

// File: rtl/sram_byte_ctl_chk.sv
module sram_byte_ctl_chk #(
  parameter int ADDR_W       = 18,
  parameter int WRITE_CYCLES = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_ce_n,
  input logic              mem_we_n,
  input logic              mem_oe_n,
  input logic              mem_lb_n,
  input logic              mem_ub_n,
  input logic              mem_dq_oe
);
  logic [15:0] we_low_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)         we_low_cnt <= '0;
    else if (!mem_we_n) we_low_cnt <= we_low_cnt + 1'b1;
    else                we_low_cnt <= '0;
  end

  AST_CE_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_ce_n |-> !req_ready); // R2
  AST_WE_SETUP: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_we_n) |-> ($past(!mem_ce_n) && $stable(mem_addr))); // R3
  AST_WE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> (!mem_ce_n && $stable(mem_addr))); // R3
  AST_WE_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> (we_low_cnt == 16'(WRITE_CYCLES))); // R3
  AST_DRIVE_IN_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> !mem_we_n); // R5
  AST_NO_CONTENTION: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |-> !mem_dq_oe); // R6
  AST_OE_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_oe_n) |-> $past(!mem_dq_oe)); // R6
  AST_IDLE_PINS: assert property (@(posedge clk) disable iff (!rst_n)
    mem_ce_n |-> (mem_lb_n && mem_ub_n && mem_oe_n && mem_we_n)); // R8
endmodule

bind sram_byte_ctl sram_byte_ctl_chk #(
  .ADDR_W       (ADDR_W),
  .WRITE_CYCLES (WRITE_CYCLES)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_ready (req_ready),
  .mem_addr  (mem_addr),
  .mem_ce_n  (mem_ce_n),
  .mem_we_n  (mem_we_n),
  .mem_oe_n  (mem_oe_n),
  .mem_lb_n  (mem_lb_n),
  .mem_ub_n  (mem_ub_n),
  .mem_dq_oe (mem_dq_oe)
);

// File: tb/sram_byte_ctl_tb_top.sv
module sram_byte_ctl_tb_top;
  localparam int AW = 18;
  localparam int RC = 2;
  localparam int WC = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic [1:0] req_mask = '0;
  logic req_ready, rsp_valid;
  logic [15:0] rsp_rdata;
  logic [AW-1:0] mem_addr;
  logic mem_ce_n, mem_we_n, mem_oe_n, mem_lb_n, mem_ub_n, mem_dq_oe;
  logic [15:0] mem_dq_out, mem_dq_in;

  int checks = 0, failures = 0, cyc = 0;
  logic [15:0] sram[int];
  logic [15:0] shadow[int];
  logic [47:0] exp_q[$];
  logic [15:0] cur_wdata = '0;
  logic [1:0]  cur_mask = '0;
  int we_run = 0, oe_run = 0;
  logic prev_we_n = 1'b1, prev_ce_n = 1'b1, prev_dq_oe = 1'b0, prev_oe_n = 1'b1;

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  sram_byte_ctl #(.ADDR_W(AW), .READ_CYCLES(RC), .WRITE_CYCLES(WC)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_mask(req_mask), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n),
    .mem_oe_n(mem_oe_n), .mem_lb_n(mem_lb_n), .mem_ub_n(mem_ub_n),
    .mem_dq_out(mem_dq_out), .mem_dq_in(mem_dq_in), .mem_dq_oe(mem_dq_oe));

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h at cycle %0d", req, act, exp, cyc);
    end
  endtask

  function automatic logic [15:0] rd_word(input logic [15:0] m[int], input int a);
    return m.exists(a) ? m[a] : 16'h0000;
  endfunction

  // behavioural memory: undriven lanes return a filler pattern
  always_comb begin
    mem_dq_in = 16'hA5A5;
    if (!mem_ce_n && !mem_oe_n && mem_we_n) begin
      if (!mem_lb_n) mem_dq_in[7:0]  = rd_word(sram, int'(mem_addr))[7:0];
      if (!mem_ub_n) mem_dq_in[15:8] = rd_word(sram, int'(mem_addr))[15:8];
    end
  end

  always @(posedge clk) begin
    if (!mem_ce_n && !mem_we_n && mem_dq_oe) begin
      logic [15:0] w;
      w = rd_word(sram, int'(mem_addr));
      if (!mem_lb_n) w[7:0]  = mem_dq_out[7:0];
      if (!mem_ub_n) w[15:8] = mem_dq_out[15:8];
      sram[int'(mem_addr)] = w;
    end
  end

  // pin and response monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (rsp_valid) begin
        if (exp_q.size() == 0) chk(1'b0, "R9 unexpected response", 32'(rsp_rdata), 0);
        else begin
          logic [47:0] e;
          e = exp_q.pop_front();
          chk(rsp_rdata == e[47:32], "R7 read data", 32'(rsp_rdata), 32'(e[47:32]));
          chk(cyc == int'(e[31:0]), "R7 response cycle", 32'(cyc), e[31:0]);
        end
      end
      if (mem_dq_oe) begin
        chk(!mem_we_n, "R5 drive outside pulse", 32'(mem_we_n), 0);
        chk(mem_dq_out == cur_wdata, "R5 write data", 32'(mem_dq_out), 32'(cur_wdata));
      end
      if (!mem_ce_n)
        chk({mem_ub_n, mem_lb_n} == ~cur_mask, "R4 lane enables", 32'({mem_ub_n, mem_lb_n}), 32'(~cur_mask));
      if (!mem_oe_n) chk(!mem_dq_oe && mem_we_n, "R6 bus contention", 32'({mem_dq_oe, mem_we_n}), 1);
      if (prev_we_n && !mem_we_n) chk(!prev_ce_n, "R3 setup cycle", 32'(prev_ce_n), 0);
      if (!prev_we_n && mem_we_n) begin
        chk(we_run == WC, "R3 pulse width", 32'(we_run), 32'(WC));
        chk(!mem_ce_n, "R3 hold cycle", 32'(mem_ce_n), 0);
      end
      if (prev_oe_n && !mem_oe_n) chk(!prev_dq_oe, "R6 release before oe", 32'(prev_dq_oe), 0);
      if (!prev_oe_n && mem_oe_n) chk(oe_run == RC, "R6 oe width", 32'(oe_run), 32'(RC));
      we_run = mem_we_n ? 0 : we_run + 1;
      oe_run = mem_oe_n ? 0 : oe_run + 1;
      prev_we_n = mem_we_n; prev_ce_n = mem_ce_n;
      prev_dq_oe = mem_dq_oe; prev_oe_n = mem_oe_n;
    end
  end

  task automatic issue(input bit wr, input int a, input logic [15:0] d, input logic [1:0] m);
    int acc, busy;
    req_valid = 1'b1; req_write = wr; req_addr = AW'(a); req_wdata = d; req_mask = m;
    while (!req_ready) @(negedge clk);
    acc = cyc + 1;
    cur_wdata = d; cur_mask = m;
    if (wr) begin
      logic [15:0] w;
      w = rd_word(shadow, a);
      if (m[0]) w[7:0] = d[7:0];
      if (m[1]) w[15:8] = d[15:8];
      shadow[a] = w;
    end else begin
      logic [15:0] e;
      e = rd_word(shadow, a);
      if (!m[0]) e[7:0] = 8'h00;
      if (!m[1]) e[15:8] = 8'h00;
      exp_q.push_back({e, 32'(acc + ((m == 2'b00) ? 0 : RC))});
    end
    @(negedge clk);
    req_valid = 1'b0;
    if (m == 2'b00) begin
      chk(req_ready && mem_ce_n, "R8 empty mask stays idle", 32'({req_ready, mem_ce_n}), 3);
    end else begin
      busy = 0;
      while (!req_ready) begin busy++; @(negedge clk); end
      chk(busy == (wr ? WC + 2 : RC), "R2 busy length", 32'(busy), 32'(wr ? WC + 2 : RC));
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    chk(1'b0, "watchdog expired", 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(req_ready && mem_ce_n && mem_we_n && mem_oe_n && mem_lb_n && mem_ub_n
        && !mem_dq_oe && !rsp_valid, "R1 reset state",
        32'({req_ready, mem_ce_n, mem_we_n, mem_oe_n, mem_lb_n, mem_ub_n, mem_dq_oe, rsp_valid}), 32'hFC);
    rst_n = 1'b1;
    @(negedge clk);
    issue(1, 0, 16'h1234, 2'b11);
    issue(1, (1 << AW) - 1, 16'hBEEF, 2'b11);
    issue(1, 16'h0ABC, 16'hCAFE, 2'b11);
    issue(0, 0, 16'h0, 2'b11);
    issue(0, (1 << AW) - 1, 16'h0, 2'b11);
    issue(1, 16'h0ABC, 16'h5577, 2'b01);   // R4 low lane only
    issue(0, 16'h0ABC, 16'h0, 2'b11);
    issue(1, 16'h0ABC, 16'h99EE, 2'b10);   // R4 high lane only
    issue(0, 16'h0ABC, 16'h0, 2'b11);
    issue(0, 16'h0ABC, 16'h0, 2'b01);      // R7 high lane zeroed
    issue(0, 16'h0ABC, 16'h0, 2'b10);      // R7 low lane zeroed
    issue(0, 16'h0ABC, 16'h0, 2'b00);      // R8 empty read
    issue(1, 0, 16'hFFFF, 2'b00);          // R8 empty write
    issue(0, 0, 16'h0, 2'b11);
    for (int i = 0; i < 40; i++) begin
      issue(i % 3 != 0, int'($urandom_range(0, 7)), 16'($urandom), 2'($urandom));
    end
    repeat (RC + 4) @(negedge clk);
    chk(exp_q.size() == 0, "R9 all reads answered", 32'(exp_q.size()), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule